// File: doc/BRIEF.md
# Interrupt-Capable Eight-Pin I/O Port

This block is an eight-pin general-purpose I/O port on a simple register bus. Each pin can be an output or an input. An output pin drives the value held in the data register. An input pin drives a high level on its output side. Input pins first pass through a two-flop synchronizer. Each input can then raise an interrupt. The trigger is set per pin: a chosen level, a chosen edge, or any edge.

Detected events collect in a sticky raw status register. Software clears status bits by writing ones to a clear address. A per-pin mask feeds a single registered interrupt line. Bus reads are registered and return the value one clock after the read strobe.

Top module: `gpio_irq_port`

## Requirements
- R1: After synchronous reset, all configuration registers and the status register are 0, `pin_out` is all ones, `irq` is 0 and `bus_rdata` is 0.
- R2: One clock after a register update, each `pin_out` bit equals the data bit for pins whose direction bit is 1, and equals 1 for pins whose direction bit is 0.
- R3: Register addresses are: 0 data, 1 direction, 2 sense, 3 both-edges, 4 event, 5 mask, 6 raw status (read only), 7 masked status (read only) and 8 clear (write only, reads 0). For address 0, a read returns the synchronized pin for input bits and the data register for output bits.
- R4: For an input pin with sense=0 and both-edges=0, a change of the synchronized input sets its status bit only when the new level equals the event bit. Event 1 selects a rising edge and event 0 a falling edge.
- R5: For an input pin with sense=0 and both-edges=1, any change of the synchronized input sets its status bit.
- R6: For an input pin with sense=1, the status bit is set in every cycle in which the synchronized input equals the event bit.
- R7: Status bits are sticky and only a write of 1 to the matching bit at address 8 clears them. A clear overrides detection in the same cycle. If a level condition still holds, the bit sets again one cycle later.
- R8: `irq` is a registered OR of (status AND mask). Address 7 reads (status AND mask).
- R9: Pins whose direction bit is 1 never set their status bit, whatever their pin activity or configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output levels |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume two things about the bus: `bus_wr` and `bus_rd` are never asserted together, and a clear write is a single-cycle strobe. The bench changes inputs only on falling clock edges. It issues each bus access as a one-cycle strobe. It holds `pin_in` low through reset, so the synchronizer and the previous-sample register start out equal. Pin patterns are held for four cycles before status is read, which covers the synchronizer and detection latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA   = 4'd0,
    REG_DIR    = 4'd1,
    REG_SENSE  = 4'd2,
    REG_BOTH   = 4'd3,
    REG_EVENT  = 4'd4,
    REG_MASK   = 4'd5,
    REG_RAW    = 4'd6,
    REG_MASKED = 4'd7,
    REG_CLEAR  = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic chg, match;
    assign chg   = lvl[i] ^ prev_q[i];
    assign match = (lvl[i] == evt[i]);

    always_comb begin
      if (dir[i])        hit[i] = 1'b0;
      else if (sense[i]) hit[i] = match;
      else if (both[i])  hit[i] = chg;
      else               hit[i] = chg & match;
    end

    always_ff @(posedge clk) begin
      if (rst)         status[i] <= 1'b0;
      else if (clr[i]) status[i] <= 1'b0;
      else if (hit[i]) status[i] <= 1'b1;
    end

    a_r6_level_sets: assert property (@(posedge clk) disable iff (rst)
      (!dir[i] && sense[i] && (lvl[i] == evt[i]) && !clr[i]) |=> status[i]);
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (status[i] && !clr[i]) |=> status[i]);
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
      clr[i] |=> !status[i]);
    a_r9_output_quiet: assert property (@(posedge clk) disable iff (rst)
      (dir[i] && !status[i] && !clr[i]) |=> !status[i]);
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic              irq
);
  logic [W-1:0] data_q, dir_q, sense_q, both_q, evt_q, mask_q;
  logic [W-1:0] pin_s, status, clr_w, rd_mux;

  gpio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  assign clr_w = (bus_wr && bus_addr == REG_CLEAR) ? bus_wdata : '0;

  gpio_irq_detect #(.W(W)) u_det (
    .clk(clk), .rst(rst), .lvl(pin_s), .dir(dir_q), .sense(sense_q),
    .both(both_q), .evt(evt_q), .clr(clr_w), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      evt_q   <= '0;
      mask_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        REG_DATA:  data_q  <= bus_wdata;
        REG_DIR:   dir_q   <= bus_wdata;
        REG_SENSE: sense_q <= bus_wdata;
        REG_BOTH:  both_q  <= bus_wdata;
        REG_EVENT: evt_q   <= bus_wdata;
        REG_MASK:  mask_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      REG_DATA:   rd_mux = (pin_s & ~dir_q) | (data_q & dir_q);
      REG_DIR:    rd_mux = dir_q;
      REG_SENSE:  rd_mux = sense_q;
      REG_BOTH:   rd_mux = both_q;
      REG_EVENT:  rd_mux = evt_q;
      REG_MASK:   rd_mux = mask_q;
      REG_RAW:    rd_mux = status;
      REG_MASKED: rd_mux = status & mask_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pin_out   <= '1;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      pin_out <= (data_q & dir_q) | ~dir_q;
      irq     <= |(status & mask_q);
    end
  end

  a_r2_inputs_drive_high: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_out | $past(dir_q)) == {W{1'b1}}));
  a_r8_irq_off: assert property (@(posedge clk) disable iff (rst)
    ((status & mask_q) == '0) |=> !irq);
  a_r8_irq_on: assert property (@(posedge clk) disable iff (rst)
    ((status & mask_q) != '0) |=> irq);
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int W = 8;
  localparam logic [W-1:0] CFG_DIR   = 8'h40;
  localparam logic [W-1:0] CFG_SENSE = 8'h18;
  localparam logic [W-1:0] CFG_BOTH  = 8'h44;
  localparam logic [W-1:0] CFG_EVT   = 8'h89;
  localparam logic [W-1:0] CFG_MASK  = 8'hDF;
  localparam int NVEC = 10;
  localparam logic [W-1:0] VEC [NVEC] = '{8'h01, 8'h03, 8'h06, 8'h1C, 8'h00,
                                          8'hFF, 8'hA0, 8'h5A, 8'h00, 8'h24};

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0, irq;
  logic [3:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_port #(.W(W)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [W-1:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [W-1:0] lvl_hits(logic [W-1:0] p);
    return CFG_SENSE & ~(p ^ CFG_EVT) & ~CFG_DIR;
  endfunction

  function automatic logic [W-1:0] edge_hits(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] ch = a ^ b;
    return ~CFG_SENSE & ~CFG_DIR & ch & (CFG_BOTH | ~(b ^ CFG_EVT));
  endfunction

  initial begin
    logic [W-1:0] v, prev, exp;
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pin_out", pin_out, 8'hFF);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    for (int a = 0; a < 9; a++) begin
      rd(a[3:0], v);
      check("R1 regs", v, 8'h00);
    end
    // R2: output drive
    wr(4'd0, 8'h40); wr(4'd1, CFG_DIR); @(negedge clk);
    check("R2 out high", pin_out, 8'hFF);
    wr(4'd0, 8'h00); @(negedge clk);
    check("R2 out low", pin_out, 8'hBF);
    wr(4'd0, 8'hBF); @(negedge clk);
    check("R2 inputs stay high", pin_out, 8'hBF);
    // R3: config readback and data read mixing
    wr(4'd2, CFG_SENSE); wr(4'd3, CFG_BOTH); wr(4'd4, CFG_EVT); wr(4'd5, CFG_MASK);
    rd(4'd4, v); check("R3 event readback", v, CFG_EVT);
    rd(4'd5, v); check("R3 mask readback", v, CFG_MASK);
    @(negedge clk); pin_in = 8'h42; repeat (3) @(negedge clk);
    rd(4'd0, v); check("R3 data mix", v, 8'h02);
    wr(4'd0, 8'h40);
    rd(4'd0, v); check("R3 data mix out", v, 8'h42);
    pin_in = 8'h00; repeat (4) @(negedge clk);
    wr(4'd8, 8'hFF);
    prev = 8'h00;
    // R4 R5 R6 R9: vector walk (pin0 rise, pin1/5 fall, pin2 both, pin3 level high,
    // pin4 level low, pin6 output, pin7 rise; pin5 masked)
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk); pin_in = VEC[k];
      repeat (4) @(negedge clk);
      exp = lvl_hits(prev) | lvl_hits(VEC[k]) | edge_hits(prev, VEC[k]);
      rd(4'd6, v); check("R4 R5 R6 R9 raw status", v, exp);
      check("R8 irq", {7'b0, irq}, {7'b0, |(exp & CFG_MASK)});
      rd(4'd7, v); check("R8 masked status", v, exp & CFG_MASK);
      wr(4'd8, 8'hFF);
      prev = VEC[k];
    end
    // R7: clear while level-low on pin4 persists: drops one cycle then returns
    @(negedge clk); pin_in = 8'h00; repeat (4) @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd8; bus_wdata = 8'h10;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 4'd6;
    @(negedge clk); bus_rd = 1'b0;
    check("R7 cleared", bus_rdata & 8'h10, 8'h00);
    rd(4'd6, v); check("R7 level re-sets", v & 8'h10, 8'h10);
    // R7: edge bit stays set with no clear, then clears
    @(negedge clk); pin_in = 8'h01; repeat (4) @(negedge clk);
    pin_in = 8'h00; repeat (6) @(negedge clk);
    rd(4'd6, v); check("R7 sticky", v & 8'h01, 8'h01);
    wr(4'd8, 8'h01);
    rd(4'd6, v); check("R7 edge cleared", v & 8'h01, 8'h00);
    // R8: mask gates irq
    wr(4'd5, 8'h00); @(negedge clk);
    check("R8 masked off", {7'b0, irq}, 8'h00);
    wr(4'd5, 8'h10); @(negedge clk);
    check("R8 unmasked", {7'b0, irq}, 8'h01);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule